// File: doc/BRIEF.md
# Digital Lock Detector

This block tells the rest of a phase-locked loop whether the loop has settled. It watches the up and down correction pulses of a phase/frequency detector and forms their logical AND, the coincidence signal. In a settled loop both pulses are very narrow, so they overlap for only a few clock cycles in each reference period. In an unsettled loop the overlap grows and shrinks with the phase slip.

An integrating counter turns the coincidence signal into a lock decision. Each reference period whose overlap stays within a small tolerance raises the counter by one step on the reference strobe. Each clock of overlap beyond that tolerance lowers the counter by three steps. Because of this asymmetry, loss of lock is reported several times faster than lock is gained, and a brief moment of phase coincidence during acquisition cannot produce a lock report. The lock output is active low. It asserts when the counter reaches a programmable threshold. It releases when the counter drops below half of that threshold, which gives the decision hysteresis.

All inputs are plain level signals sampled on the clock, and there is no handshake. The reference strobe is a single-cycle pulse that marks the last cycle of each reference period.

Top module: `lock_detector`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `lock_n_o` is 1 (unlocked) and the integrator holds 0.
- R2: Only a cycle in which `up_i` and `dn_i` are both 1 counts as coincidence. A pulse on either input alone never lowers the integrator and never stops the increment at the end of its period.
- R3: Within one reference period, the first NARROW_MAX coincident cycles (2 by default) are tolerated. Each further coincident cycle in that period lowers the integrator by DEC_MULT*INC_STEP (3 by default).
- R4: On a cycle with `ref_stb_i` = 1, the integrator rises by INC_STEP, but only if no coincident cycle of the ending period went past the tolerance. The strobe cycle itself belongs to the ending period. If the strobe cycle is itself a cycle past the tolerance, only the decrement applies.
- R5: A decrement never takes the integrator below 0.
- R6: An increment never takes the integrator above 2^CNT_W-1.
- R7: When unlocked, `lock_n_o` goes to 0 one cycle after the integrator becomes greater than or equal to `thresh_i`.
- R8: When locked, `lock_n_o` goes back to 1 one cycle after the integrator falls below floor(`thresh_i`/2). It stays at 0 as long as the integrator is at or above that level.
- R9: Starting from reset with clean periods only, `lock_n_o` is still 1 right after the strobe of period `thresh_i` (with INC_STEP = 1). It is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Up correction pulse from the phase detector |
| dn_i | input | 1 | Down correction pulse from the phase detector |
| ref_stb_i | input | 1 | One-cycle pulse on the last cycle of each reference period |
| thresh_i | input | CNT_W | Lock threshold (integration constant) |
| lock_n_o | output | 1 | Lock indication, 0 when locked |

## Verification
The integrator is not visible at the ports, so its value has to be inferred from when `lock_n_o` changes. Saturation at the top is the hardest case to reach. The threshold is set to the all-ones value, more than 2^CNT_W clean periods are driven to pin the counter at its ceiling, and then one long overlap is applied. The number of cycles until release shows whether the counter stayed at the ceiling or wrapped. Saturation at zero is shown the same way: the counter is driven into the floor, and then the exact number of clean periods needed to lock is measured. A pseudo-random pulse stream is also compared cycle by cycle against an arithmetic model in the bench.

// File: rtl/ld_pkg.sv
package ld_pkg;

  typedef enum logic {
    LD_UNLOCKED = 1'b0,
    LD_LOCKED   = 1'b1
  } ld_state_e;

  typedef struct packed {
    logic dec;
    logic inc;
  } ld_evt_t;

endpackage

// File: rtl/ld_coinc_window.sv
module ld_coinc_window
  import ld_pkg::*;
#(
  parameter int TOL_W      = 3,
  parameter int NARROW_MAX = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    up_i,
  input  logic    dn_i,
  input  logic    stb_i,
  output ld_evt_t evt_o
);

  localparam logic [TOL_W-1:0] TOL = TOL_W'(NARROW_MAX);

  logic             coin;
  logic             excess;
  logic [TOL_W-1:0] wcnt_q;
  logic             wide_q;

  assign coin   = up_i & dn_i;
  assign excess = coin && (wcnt_q >= TOL);

  always_comb begin
    evt_o     = '0;
    evt_o.dec = excess;
    evt_o.inc = stb_i && !wide_q && !excess;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      wide_q <= 1'b0;
    end else if (stb_i) begin
      wcnt_q <= '0;
      wide_q <= 1'b0;
    end else begin
      if (coin && (wcnt_q < TOL)) wcnt_q <= wcnt_q + 1'b1;
      if (excess)                 wide_q <= 1'b1;
    end
  end

  generate
    if (NARROW_MAX > 0) begin : g_tol
      // R3: the first coincident cycle of a fresh period is always tolerated
      a_r3_first_tolerated: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> !evt_o.dec);
    end else begin : g_notol
      // R3: with no tolerance every coincident cycle counts against lock
      a_r3_no_tolerance: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && dn_i) |-> evt_o.dec);
    end
  endgenerate

  // R4: a period that went past the tolerance earns no increment
  a_r4_wide_blocks_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (excess && !stb_i) |=> (stb_i |-> !evt_o.inc));

endmodule

// File: rtl/ld_integrator.sv
module ld_integrator
  import ld_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int INC_STEP = 1,
  parameter int DEC_MULT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ld_evt_t          evt_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] INC_V  = CNT_W'(INC_STEP);
  localparam logic [CNT_W-1:0] DEC_V  = CNT_W'(INC_STEP * DEC_MULT);
  localparam logic [CNT_W-1:0] MAX_V  = '1;
  localparam logic [CNT_W-1:0] HEAD_V = MAX_V - INC_V;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (evt_i.dec) begin
      cnt_d = (cnt_q >= DEC_V) ? (cnt_q - DEC_V) : '0;
    end else if (evt_i.inc) begin
      cnt_d = (cnt_q <= HEAD_V) ? (cnt_q + INC_V) : MAX_V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5: a decrement never wraps upward past zero
  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.dec |=> (cnt_q <= $past(cnt_q)));

  // R6: an increment never wraps downward past the ceiling
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.inc |=> (cnt_q >= $past(cnt_q)));

  // R4: without an event the integrator holds
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.inc && !evt_i.dec) |=> $stable(cnt_q));

endmodule

// File: rtl/ld_hyst_cmp.sv
module ld_hyst_cmp
  import ld_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             locked_o
);

  ld_state_e        state_q;
  ld_state_e        state_d;
  logic [CNT_W-1:0] release_lvl;

  assign release_lvl = thresh_i >> 1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_UNLOCKED: if (cnt_i >= thresh_i)  state_d = LD_LOCKED;
      LD_LOCKED:   if (cnt_i < release_lvl) state_d = LD_UNLOCKED;
      default:     state_d = LD_UNLOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LD_UNLOCKED;
    else        state_q <= state_d;
  end

  assign locked_o = (state_q == LD_LOCKED);

  // R8: once locked, a count at or above half the threshold keeps lock
  a_r8_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && (cnt_i >= (thresh_i >> 1))) |=> locked_o);

  // R7: while unlocked, a count below threshold keeps it unlocked
  a_r7_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && (cnt_i < thresh_i)) |=> !locked_o);

endmodule

// File: rtl/lock_detector.sv
module lock_detector
  import ld_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int INC_STEP   = 1,
  parameter int DEC_MULT   = 3,
  parameter int TOL_W      = 3,
  parameter int NARROW_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             ref_stb_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             lock_n_o
);

  ld_evt_t          evt;
  logic [CNT_W-1:0] cnt;
  logic             locked;

  ld_coinc_window #(
    .TOL_W      (TOL_W),
    .NARROW_MAX (NARROW_MAX)
  ) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .up_i  (up_i),
    .dn_i  (dn_i),
    .stb_i (ref_stb_i),
    .evt_o (evt)
  );

  ld_integrator #(
    .CNT_W    (CNT_W),
    .INC_STEP (INC_STEP),
    .DEC_MULT (DEC_MULT)
  ) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt),
    .cnt_o (cnt)
  );

  ld_hyst_cmp #(
    .CNT_W (CNT_W)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_i    (cnt),
    .thresh_i (thresh_i),
    .locked_o (locked)
  );

  assign lock_n_o = ~locked;

  // R2: without a coincident cycle the integrator never drops
  a_r2_single_pulse_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_i && dn_i) |=> (cnt >= $past(cnt)));

  // R4: the integrator only rises on a strobe cycle
  a_r4_inc_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb_i |=> (cnt <= $past(cnt)));

  // R7: lock is only entered from a count at or above threshold
  a_r7_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n_o) |-> ($past(cnt) >= $past(thresh_i)));

  // R8: lock is only released from a count below half the threshold
  a_r8_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n_o) |-> ($past(cnt) < ($past(thresh_i) >> 1)));

endmodule

// File: tb/tb_lock_detector.sv
`timescale 1ns/1ps
module tb_lock_detector;

  localparam int CNT_W = 8;
  localparam int NM    = 2;
  localparam int DEC   = 3;
  localparam int CMAX  = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             up_i = 1'b0;
  logic             dn_i = 1'b0;
  logic             ref_stb_i = 1'b0;
  logic [CNT_W-1:0] thresh_i = 8'd8;
  logic             lock_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cnt, m_wc;
  bit m_wide, m_lock;

  always #4 clk = ~clk;

  lock_detector dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .ref_stb_i (ref_stb_i),
    .thresh_i  (thresh_i),
    .lock_n_o  (lock_n_o)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_i = 0; dn_i = 0; ref_stb_i = 0;
    repeat (3) @(negedge clk);
    check(lock_n_o === 1'b1, "R1 during reset", lock_n_o, 1);
    rst_n = 1'b1;
    m_cnt = 0; m_wc = 0; m_wide = 0; m_lock = 0;
    @(posedge clk);
    @(negedge clk);
    check(lock_n_o === 1'b1, "R1 after reset", lock_n_o, 1);
  endtask

  // one clock: drive at negedge, update model on edge, compare at next negedge
  task automatic step(input bit u, input bit d, input bit s, input string req);
    bit coin, exc, inc, nl;
    up_i = u; dn_i = d; ref_stb_i = s;
    @(posedge clk);
    coin = u & d;
    exc  = coin && (m_wc >= NM);
    inc  = s && !m_wide && !exc;
    nl   = m_lock;
    if (!m_lock && m_cnt >= int'(thresh_i)) nl = 1;
    if (m_lock && m_cnt < int'(thresh_i >> 1)) nl = 0;
    m_lock = nl;
    if (exc)      m_cnt = (m_cnt >= DEC) ? m_cnt - DEC : 0;
    else if (inc) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
    if (s) begin m_wc = 0; m_wide = 0; end
    else begin
      if (coin && m_wc < NM) m_wc++;
      if (exc) m_wide = 1;
    end
    @(negedge clk);
    check(lock_n_o === !m_lock, req, lock_n_o, !m_lock);
    up_i = 0; dn_i = 0; ref_stb_i = 0;
  endtask

  // a reference period of len cycles, coincidence on the first w cycles
  task automatic period(input int len, input int w, input string req);
    for (int i = 0; i < len; i++)
      step(i < w, i < w, i == len - 1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    do_reset();

    // R9 / R7: lock timing against threshold sweep
    for (int t = 1; t <= 12; t++) begin
      thresh_i = 8'(t);
      do_reset();
      for (int p = 0; p < t; p++) period(4, 0, "R9 clean periods");
      check(lock_n_o === 1'b1, "R9 not yet locked", lock_n_o, 1);
      step(0, 0, 0, "R7 lock entry");
      check(lock_n_o === 1'b0, "R9 locked one cycle later", lock_n_o, 0);
    end

    // R2: single-sided pulses never cost lock
    thresh_i = 8'd8;
    do_reset();
    for (int p = 0; p < 9; p++) period(4, 0, "R2 setup");
    for (int p = 0; p < 20; p++) begin
      for (int i = 0; i < 6; i++) step(i < 5, 1'b0, i == 5, "R2 up only");
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i == 5, "R2 down only");
    end
    check(lock_n_o === 1'b0, "R2 still locked", lock_n_o, 0);

    // R3: coincidence width sweep on a locked loop
    for (int w = 0; w <= 6; w++) begin
      thresh_i = 8'd10;
      do_reset();
      for (int p = 0; p < 10; p++) period(3, 0, "R3 setup");
      for (int p = 0; p < 20; p++) period(8, w, "R3 width sweep");
      check(lock_n_o === ((w <= NM) ? 1'b0 : 1'b1), "R3 final lock state",
            lock_n_o, (w <= NM) ? 0 : 1);
    end

    // R4: excess coincidence landing on the strobe cycle
    thresh_i = 8'd6;
    do_reset();
    for (int p = 0; p < 8; p++) period(4, 0, "R4 setup");
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < 5; i++) step(i >= 2, i >= 2, i == 4, "R4 strobe excess");
    check(lock_n_o === 1'b1, "R4 released", lock_n_o, 1);

    // R5: floor at zero, then exact lock count
    thresh_i = 8'd5;
    do_reset();
    for (int p = 0; p < 10; p++) period(10, 10, "R5 drive to floor");
    for (int p = 0; p < 5; p++) period(3, 0, "R5 recover");
    check(lock_n_o === 1'b1, "R5 not yet locked", lock_n_o, 1);
    step(0, 0, 0, "R5 lock");
    check(lock_n_o === 1'b0, "R5 lock from zero", lock_n_o, 0);

    // R6: ceiling, then measured release time
    thresh_i = 8'd255;
    do_reset();
    for (int p = 0; p < 270; p++) period(2, 0, "R6 fill");
    check(lock_n_o === 1'b0, "R6 locked at ceiling", lock_n_o, 0);
    begin
      int n;
      n = 0;
      while (lock_n_o === 1'b0 && n < 100) begin
        step(1, 1, 0, "R6 drain");
        n++;
      end
      check(n == 46, "R6 release cycles", n, 46);
    end

    // R8: hysteresis band
    thresh_i = 8'd20;
    do_reset();
    for (int p = 0; p < 20; p++) period(3, 0, "R8 setup");
    step(0, 0, 0, "R8 lock");
    for (int i = 0; i < 5; i++) step(1, 1, 0, "R8 drop to 11");
    step(0, 0, 0, "R8 settle");
    check(lock_n_o === 1'b0, "R8 held above half", lock_n_o, 0);
    step(1, 1, 0, "R8 drop to 8");
    step(0, 0, 0, "R8 release");
    check(lock_n_o === 1'b1, "R8 released below half", lock_n_o, 1);

    // mixed pseudo-random stream against the model
    thresh_i = 8'd6;
    do_reset();
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] & lf[1], lf[2] & lf[3] & lf[4], (c % 6) == 5, "R3 R4 R7 R8 random");
      end
    end

    done = 1;
    summary();
  end

endmodule